// File: doc/BRIEF.md
# Frequency Synthesizer Serial Program Loader

This block writes one programming word into an external frequency synthesizer that is controlled over two software-style lines: a serial clock line and a serial data line. A single start pulse launches a complete load. The block drives an unlock preamble, a start marker, the payload bits and a stop marker, then waits a settling interval before it reports that the new frequency can be trusted.

The payload is built from a divider word and a small register-select field. The select field sits directly above the divider word, and any remaining upper bits are zero. Payload bits go out least significant first. Each bit uses four line states, and the complement of the bit frames the true value. Every line state is held for the same programmable number of system clocks, so the serial rate can be matched to the synthesizer from a fast core clock. The settling wait is a separate parameter, normally set to about a tenth of a second.

Top module: `clksyn_loader`

## Requirements
- R1: After reset and whenever no load is in progress, the lines rest at data=1, clock=1, `busy_o` is 0 and `done_o` is 0.
- R2: The payload is `{zero padding, reg_sel_i, div_word_i}`: the divider word fills bits 0 to DIV_W-1, the select field fills the next SEL_W bits, and the remaining bits up to PAYLOAD_W-1 are 0. Both inputs are captured in the cycle the start is accepted.
- R3: A load begins with PREAMBLE_PAIRS pairs of line states, each pair being (data=1, clock=0) then (data=1, clock=1).
- R4: The start marker follows as five states (data, clock): (1,0), (0,0), (0,1), (0,0), (0,1).
- R5: The PAYLOAD_W payload bits follow, least significant first. A bit b takes four states (data, clock): (~b,1), (~b,0), (b,0), (b,1).
- R6: The stop marker follows as (1,1), (1,0), (1,1). After it the lines return to (1,1).
- R7: Each line state is held for exactly HOLD_CYCLES clocks. The first state appears on the lines two clock edges after the edge that accepts the start.
- R8: `done_o` is a one-cycle pulse that rises SETTLE_CYCLES clocks after the last stop state ends. `busy_o` falls in that same cycle, and `done_o` never pulses at any other time.
- R9: A start pulse that arrives while `busy_o` is 1 is ignored. Changes to `div_word_i` or `reg_sel_i` during a load do not alter the waveform or its timing.
- R10: The data line and the clock line never change in the same clock cycle.
- R11: `busy_o` is 1 from the cycle after an accepted start until the `done_o` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a load; accepted only when idle |
| div_word_i | input | DIV_W | Divider word, low part of the payload |
| reg_sel_i | input | SEL_W | Synthesizer register select, placed above the divider word |
| syn_clk_o | output | 1 | Serial clock line to the synthesizer |
| syn_dat_o | output | 1 | Serial data line to the synthesizer |
| busy_o | output | 1 | Load or settling wait in progress |
| done_o | output | 1 | One-cycle pulse when the settling wait ends |

## Verification
The embedded assertions check the timing rules on every cycle: only one line moves at a time, the lines rest high when idle, the step index holds between hold-counter expiries, `done_o` is a single-cycle pulse that only follows the settling state, busy starts right after an accepted start, and the captured payload stays frozen while busy. Only the bench scenarios can show that the waveform is correct state by state. For several payload patterns, the bench compares every cycle of the preamble, start marker, four-phase bits and stop marker against a model built from the requirements. It also shows the exact position of the done pulse, that a mid-load start and mid-load input changes have no effect, and that the lines recover after a reset during a load.

// File: rtl/clksyn_pkg.sv
package clksyn_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_SEND   = 2'd1,
      ST_SETTLE = 2'd2
   } seq_state_e;

   // Fixed shape of the serial frame.
   localparam int MARK_STEPS  = 5;   // start marker states
   localparam int TAIL_STEPS  = 3;   // stop marker states
   localparam int BIT_PHASES  = 4;   // line states per payload bit

   function automatic int frame_steps(input int pairs, input int pay_w);
      return 2 * pairs + MARK_STEPS + BIT_PHASES * pay_w + TAIL_STEPS;
   endfunction

   function automatic int width_for(input int count);
      return (count > 1) ? $clog2(count) : 1;
   endfunction

endpackage

// File: rtl/clksyn_interval_ctr.sv
module clksyn_interval_ctr #(
   parameter int LIMIT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic en_i,
   output logic last_o
);
   localparam int CW = clksyn_pkg::width_for(LIMIT);
   localparam logic [CW-1:0] TOP = CW'(LIMIT - 1);

   if (LIMIT < 1) begin : g_bad_limit
      $error("clksyn_interval_ctr: LIMIT must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr_i) begin
         cnt_q <= '0;
      end else if (en_i) begin
         cnt_q <= last_o ? '0 : cnt_q + 1'b1;
      end
   end

   assign last_o = (cnt_q == TOP);

   // R7: counter never runs past its terminal value
   p_cnt_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= TOP);

endmodule

// File: rtl/clksyn_seq_ctrl.sv
module clksyn_seq_ctrl
   import clksyn_pkg::*;
#(
   parameter int HOLD_CYCLES    = 16,
   parameter int SETTLE_CYCLES  = 1000000,
   parameter int PREAMBLE_PAIRS = 6,
   parameter int PAYLOAD_W      = 24,
   parameter int DIV_W          = 21,
   parameter int SEL_W          = 2,
   parameter int STEP_W         = 7
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_i,
   input  logic [DIV_W-1:0]     div_word_i,
   input  logic [SEL_W-1:0]     reg_sel_i,
   output seq_state_e           state_o,
   output logic [STEP_W-1:0]    step_o,
   output logic [PAYLOAD_W-1:0] payload_o,
   output logic                 busy_o,
   output logic                 done_o
);
   localparam int TOTAL = frame_steps(PREAMBLE_PAIRS, PAYLOAD_W);
   localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(TOTAL - 1);

   if (STEP_W < width_for(TOTAL)) begin : g_bad_stepw
      $error("clksyn_seq_ctrl: STEP_W too narrow for frame length");
   end

   seq_state_e            state_q;
   logic [STEP_W-1:0]     step_q;
   logic [PAYLOAD_W-1:0]  payload_q;
   logic                  done_q;
   logic                  hold_last;
   logic                  settle_last;
   logic                  accept;

   assign accept = (state_q == ST_IDLE) && start_i;

   // Per-step hold timer, cleared whenever no step is on the lines.
   clksyn_interval_ctr #(.LIMIT(HOLD_CYCLES)) u_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (state_q != ST_SEND),
      .en_i   (state_q == ST_SEND),
      .last_o (hold_last)
   );

   // Settling timer, runs only after the stop marker.
   clksyn_interval_ctr #(.LIMIT(SETTLE_CYCLES)) u_settle (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (state_q != ST_SETTLE),
      .en_i   (state_q == ST_SETTLE),
      .last_o (settle_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         step_q    <= '0;
         payload_q <= '0;
         done_q    <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  state_q   <= ST_SEND;
                  step_q    <= '0;
                  payload_q <= PAYLOAD_W'({reg_sel_i, div_word_i});
               end
            end
            ST_SEND: begin
               if (hold_last) begin
                  if (step_q == LAST_STEP) begin
                     state_q <= ST_SETTLE;
                  end else begin
                     step_q <= step_q + 1'b1;
                  end
               end
            end
            ST_SETTLE: begin
               if (settle_last) begin
                  state_q <= ST_IDLE;
                  done_q  <= 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign state_o   = state_q;
   assign step_o    = step_q;
   assign payload_o = payload_q;
   assign busy_o    = (state_q != ST_IDLE);
   assign done_o    = done_q;

   // R7: step index only advances when the hold timer expires
   p_step_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SEND && !hold_last) |=> $stable(step_q));

   // R8: done is a single-cycle pulse
   p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

   // R8: done only ever follows the settling state
   p_done_after_settle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> ($past(state_q) == ST_SETTLE));

   // R9: a start while busy leaves the captured payload alone
   p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE && start_i) |=> $stable(payload_q));

   // R11: busy rises in the cycle after an accepted start
   p_busy_after_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> busy_o);

endmodule

// File: rtl/clksyn_line_encoder.sv
module clksyn_line_encoder
   import clksyn_pkg::*;
#(
   parameter int PREAMBLE_PAIRS = 6,
   parameter int PAYLOAD_W      = 24,
   parameter int STEP_W         = 7
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  seq_state_e           state_i,
   input  logic [STEP_W-1:0]    step_i,
   input  logic [PAYLOAD_W-1:0] payload_i,
   output logic                 syn_clk_o,
   output logic                 syn_dat_o
);
   localparam int BIT_W = width_for(PAYLOAD_W);
   localparam logic [STEP_W-1:0] MARK_BASE = STEP_W'(2 * PREAMBLE_PAIRS);
   localparam logic [STEP_W-1:0] PAY_BASE  = STEP_W'(2 * PREAMBLE_PAIRS + MARK_STEPS);
   localparam logic [STEP_W-1:0] TAIL_BASE = STEP_W'(2 * PREAMBLE_PAIRS + MARK_STEPS
                                                     + BIT_PHASES * PAYLOAD_W);

   if (STEP_W < BIT_W + 2) begin : g_bad_stepw
      $error("clksyn_line_encoder: STEP_W too narrow for payload index");
   end

   logic [STEP_W-1:0] rel_mark;
   logic [STEP_W-1:0] rel_pay;
   logic [STEP_W-1:0] rel_tail;
   logic [BIT_W-1:0]  bit_sel;
   logic [1:0]        phase;
   logic              cur_bit;
   logic              dat_d;
   logic              clk_d;

   assign rel_mark = step_i - MARK_BASE;
   assign rel_pay  = step_i - PAY_BASE;
   assign rel_tail = step_i - TAIL_BASE;
   assign phase    = rel_pay[1:0];
   assign bit_sel  = rel_pay[BIT_W+1:2];
   assign cur_bit  = payload_i[bit_sel];

   always_comb begin
      dat_d = 1'b1;
      clk_d = 1'b1;
      if (state_i == ST_SEND) begin
         if (step_i < MARK_BASE) begin
            // unlock pairs: clock toggles low/high, data held high
            clk_d = step_i[0];
         end else if (step_i < PAY_BASE) begin
            unique case (rel_mark)
               STEP_W'(0): begin dat_d = 1'b1; clk_d = 1'b0; end
               STEP_W'(1): begin dat_d = 1'b0; clk_d = 1'b0; end
               STEP_W'(2): begin dat_d = 1'b0; clk_d = 1'b1; end
               STEP_W'(3): begin dat_d = 1'b0; clk_d = 1'b0; end
               default:    begin dat_d = 1'b0; clk_d = 1'b1; end
            endcase
         end else if (step_i < TAIL_BASE) begin
            // complement first, true value second; clock low in the middle
            dat_d = phase[1] ? cur_bit : ~cur_bit;
            clk_d = (phase == 2'd0) || (phase == 2'd3);
         end else begin
            clk_d = (rel_tail != STEP_W'(1));
         end
      end
   end

   // Registered lines so the synthesizer never sees decode glitches.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         syn_dat_o <= 1'b1;
         syn_clk_o <= 1'b1;
      end else begin
         syn_dat_o <= dat_d;
         syn_clk_o <= clk_d;
      end
   end

   // R10: the two lines never move in the same cycle
   p_one_line_moves_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(syn_clk_o) |-> $stable(syn_dat_o));

   // R1: lines rest high once the sequencer has been idle for a cycle
   p_idle_lines_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (state_i == ST_IDLE && $past(state_i) == ST_IDLE) |-> (syn_dat_o && syn_clk_o));

endmodule

// File: rtl/clksyn_loader.sv
module clksyn_loader
   import clksyn_pkg::*;
#(
   parameter int HOLD_CYCLES    = 16,
   parameter int SETTLE_CYCLES  = 1000000,
   parameter int PREAMBLE_PAIRS = 6,
   parameter int PAYLOAD_W      = 24,
   parameter int DIV_W          = 21,
   parameter int SEL_W          = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [DIV_W-1:0] div_word_i,
   input  logic [SEL_W-1:0] reg_sel_i,
   output logic             syn_clk_o,
   output logic             syn_dat_o,
   output logic             busy_o,
   output logic             done_o
);
   localparam int TOTAL  = frame_steps(PREAMBLE_PAIRS, PAYLOAD_W);
   localparam int STEP_W = width_for(TOTAL);

   if (DIV_W + SEL_W > PAYLOAD_W) begin : g_bad_payload
      $error("clksyn_loader: divider and select do not fit the payload");
   end
   if (PREAMBLE_PAIRS < 1) begin : g_bad_pairs
      $error("clksyn_loader: at least one preamble pair required");
   end
   if (HOLD_CYCLES < 1 || SETTLE_CYCLES < 1) begin : g_bad_times
      $error("clksyn_loader: hold and settle times must be positive");
   end

   seq_state_e            state;
   logic [STEP_W-1:0]     step;
   logic [PAYLOAD_W-1:0]  payload;

   clksyn_seq_ctrl #(
      .HOLD_CYCLES   (HOLD_CYCLES),
      .SETTLE_CYCLES (SETTLE_CYCLES),
      .PREAMBLE_PAIRS(PREAMBLE_PAIRS),
      .PAYLOAD_W     (PAYLOAD_W),
      .DIV_W         (DIV_W),
      .SEL_W         (SEL_W),
      .STEP_W        (STEP_W)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .div_word_i (div_word_i),
      .reg_sel_i  (reg_sel_i),
      .state_o    (state),
      .step_o     (step),
      .payload_o  (payload),
      .busy_o     (busy_o),
      .done_o     (done_o)
   );

   clksyn_line_encoder #(
      .PREAMBLE_PAIRS(PREAMBLE_PAIRS),
      .PAYLOAD_W     (PAYLOAD_W),
      .STEP_W        (STEP_W)
   ) u_enc (
      .clk       (clk),
      .rst_n     (rst_n),
      .state_i   (state),
      .step_i    (step),
      .payload_i (payload),
      .syn_clk_o (syn_clk_o),
      .syn_dat_o (syn_dat_o)
   );

endmodule

// File: tb/clksyn_loader_tb.sv
`timescale 1ns/1ps
module clksyn_loader_tb;
   localparam int H     = 3;
   localparam int S     = 20;
   localparam int PAIRS = 6;
   localparam int PW    = 24;
   localparam int NSTEP = 2 * PAIRS + 5 + 4 * PW + 3;

   // {reg_sel, div_word}
   localparam logic [22:0] VEC [6] = '{
      {2'd2, 21'h000000},
      {2'd3, 21'h1FFFFF},
      {2'd0, 21'h0AAAAA},
      {2'd1, 21'h155555},
      {2'd2, 21'h012345},
      {2'd2, 21'h1C0F03}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [20:0] div_word_i = '0;
   logic [1:0]  reg_sel_i = '0;
   logic        syn_clk_o, syn_dat_o, busy_o, done_o;

   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;
   bit ended = 1'b0;

   clksyn_loader #(
      .HOLD_CYCLES(H), .SETTLE_CYCLES(S), .PREAMBLE_PAIRS(PAIRS),
      .PAYLOAD_W(PW), .DIV_W(21), .SEL_W(2)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .div_word_i(div_word_i), .reg_sel_i(reg_sel_i),
      .syn_clk_o(syn_clk_o), .syn_dat_o(syn_dat_o),
      .busy_o(busy_o), .done_o(done_o)
   );

   always #2 clk = ~clk;

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // Expected {data, clock} for frame step k.
   function automatic logic [1:0] want(input int k, input logic [23:0] p);
      logic b;
      if (k < 2 * PAIRS) return {1'b1, k[0]};
      k -= 2 * PAIRS;
      if (k < 5) return {k == 0, (k == 2) || (k == 4)};
      k -= 5;
      if (k < 4 * PW) begin
         b = p[k / 4];
         return {((k % 4) >= 2) ? b : ~b, ((k % 4) == 0) || ((k % 4) == 3)};
      end
      k -= 4 * PW;
      return {1'b1, k != 1};
   endfunction

   function automatic string tag(input int k);
      if (k < 2 * PAIRS)          return "R3/R7 preamble";
      if (k < 2 * PAIRS + 5)      return "R4/R7 start marker";
      if (k < 2 * PAIRS + 5 + 4*PW) return "R2/R5/R7 payload bit";
      return "R6/R7 stop marker";
   endfunction

   task automatic run_xfer(input logic [20:0] d, input logic [1:0] s, input bit inject);
      logic [23:0] pay;
      logic [1:0]  prev;
      int          endj;
      int          early;
      int          k;
      pay   = {1'b0, s, d};
      endj  = NSTEP * H + S + 1;
      early = 0;
      @(negedge clk);
      check(syn_dat_o && syn_clk_o && !busy_o, "R1 idle lines before start",
            {syn_dat_o, syn_clk_o, busy_o}, 3'b110);
      div_word_i = d; reg_sel_i = s; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      check(busy_o == 1'b1, "R11 busy after accepted start", busy_o, 1);
      prev = {syn_dat_o, syn_clk_o};
      for (int j = 2; j <= endj + 1; j++) begin
         @(negedge clk);
         if (inject && j == 40) begin start_i = 1'b1; div_word_i = ~d; reg_sel_i = ~s; end
         if (inject && j == 41) start_i = 1'b0;
         if (inject && j == 41)
            check(busy_o == 1'b1, "R9 still busy after ignored start", busy_o, 1);
         check(!((syn_dat_o != prev[1]) && (syn_clk_o != prev[0])),
               "R10 single line change", {syn_dat_o, syn_clk_o}, prev);
         prev = {syn_dat_o, syn_clk_o};
         if (j <= NSTEP * H + 1) begin
            k = (j - 2) / H;
            check({syn_dat_o, syn_clk_o} == want(k, pay),
                  inject ? {"R9 ", tag(k)} : tag(k), {syn_dat_o, syn_clk_o}, want(k, pay));
         end else if (j < endj) begin
            check(syn_dat_o && syn_clk_o && busy_o, "R6/R11 lines high, busy during settle",
                  {syn_dat_o, syn_clk_o, busy_o}, 3'b111);
         end
         if (j < endj && done_o) early++;
         if (j == endj)
            check(done_o && !busy_o, "R8 done pulse and busy fall",
                  {done_o, busy_o}, 2'b10);
         if (j == endj + 1)
            check(!done_o, "R8 done lasts one cycle", done_o, 0);
      end
      check(early == 0, "R8 no early done", early, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check(syn_dat_o && syn_clk_o && !busy_o && !done_o, "R1 reset state",
            {syn_dat_o, syn_clk_o, busy_o, done_o}, 4'b1100);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(syn_dat_o && syn_clk_o && !busy_o && !done_o, "R1 idle after reset",
            {syn_dat_o, syn_clk_o, busy_o, done_o}, 4'b1100);

      foreach (VEC[i]) run_xfer(VEC[i][20:0], VEC[i][22:21], 1'b0);

      // R9: start pulse and input changes mid-load are ignored
      run_xfer(21'h0F0F0F, 2'd2, 1'b1);

      // Reset in the middle of a load returns the lines to rest (R1)
      @(negedge clk);
      div_word_i = 21'h1ABCDE; reg_sel_i = 2'd2; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      repeat (100) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check(syn_dat_o && syn_clk_o && !busy_o && !done_o, "R1 reset mid-load",
            {syn_dat_o, syn_clk_o, busy_o, done_o}, 4'b1100);
      rst_n = 1'b1;
      run_xfer(21'h0007FF, 2'd2, 1'b0);

      ended = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 100000 && !ended) begin
         ended = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule